// File: doc/BRIEF.md
# Multi-Thread Event Counter Unit

This block counts hardware events for a core that runs four hardware threads. It holds two general counters. Each counter is one 32-bit word that packs a 4-bit event selector, a 4-bit thread enable mask and a 24-bit count. In every cycle each thread presents a 16-bit vector of event strobes. A counter adds the strobes of its selected event from every thread its mask enables. A few event codes, chosen by a parameter, are core-wide: they take their strobe from a separate core-level vector and ignore the mask. Alongside the two counters there is a 32-bit active-cycle counter. It advances on every cycle in which the core's activity input is high, and it cannot be stopped or written.

Software reaches all of this through a simple register bus. Writes are synchronous; reads are combinational. Each general counter drives its own overflow interrupt line. The line rises when the count wraps to zero and stays high until software clears it through a status register. A build-time parameter selects a legacy variant. In that variant a write to a counter loads the selector and mask but forces the count to zero, and no interrupt is ever raised.

Reset is asynchronous and active low. An internal two-stage synchroniser releases it on the clock.

Top module: `evctr_unit`

## Requirements
- R1: Registers are decoded on byte address bits [4:3], and address bits [2:0] are ignored. Counter 0 is at 0x00 and counter 1 at 0x08. The active-cycle counter is at 0x10. The interrupt status register is at 0x18, with bit c for counter c. A counter word is read back as event selector [31:28], thread mask [27:24] and count [23:0].
- R2: In each cycle a counter adds the number of enabled threads whose strobe for the selected event is high. Thread t drives strobe vector bits [16t+15:16t], and mask bit 24+t enables thread t. The new count is readable after the next rising clock edge and wraps modulo 2^24.
- R3: Strobes from threads whose mask bit is clear, and strobes for events other than the selected one, do not change the count.
- R4: With bits [31:24] written as zero, the counter holds its count and the count stays readable in bits [23:0].
- R5: In normal mode, a count that goes from 0xFFFFFF past zero sets that counter's own interrupt line, irq_ovf[c], after the same edge that wraps the count.
- R6: An interrupt line stays high until a write to the status register with bit c set clears it. If a wrap occurs in the same cycle as the clear, the line stays set.
- R7: A counter write takes priority over any increment in the same cycle. In normal mode all 32 written bits are stored.
- R8: Event codes flagged in GLOBAL_EVT (default 14 and 15) add core_evt[sel] once per cycle, whatever the thread mask and the thread strobes.
- R9: The active-cycle counter adds one for every cycle with thr_active high. Writes to it have no effect.
- R10: With LEGACY=1, a counter write loads bits [31:24] and clears the count to zero, and irq_ovf stays low.
- R11: Reset clears both counter words, the interrupt flags and the active-cycle counter. All registers then read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_evt | input | 64 | Per-thread event strobes, 16 per thread |
| core_evt | input | 16 | Core-wide event strobes |
| thr_active | input | 1 | Thread active in this cycle |
| bus_addr | input | 5 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_ovf | output | 2 | Overflow interrupt per counter |

## Verification
Counts, interrupt flags and the active-cycle value all change on the rising edge that samples the strobe or write, so each is due one cycle after its stimulus. Bus reads are combinational and valid in the same cycle. The bench drives every stimulus at a falling edge and applies the same inputs to a reference model on the next rising edge. It compares both interrupt lines on every falling edge, and it reads registers one step after the stimulus, at a falling edge with no write pending. After reset is released, the bench waits out the two-cycle synchroniser with idle inputs before the model starts tracking.

// File: rtl/evctr_pkg.sv
package evctr_pkg;
  parameter int NUM_THREADS = 4;
  parameter int EVT_W       = 4;
  parameter int CNT_W       = 24;
  parameter int DATA_W      = 32;
  parameter int NUM_CTR     = 2;
  parameter int NUM_EVT     = 1 << EVT_W;
  parameter int INC_W       = $clog2(NUM_THREADS + 1);
  parameter int REG_SH      = 3;   // 8-byte register stride

  typedef struct packed {
    logic [EVT_W-1:0]       sel;
    logic [NUM_THREADS-1:0] mask;
    logic [CNT_W-1:0]       cnt;
  } ctr_word_t;
endpackage

// File: rtl/evctr_rst_sync.sv
module evctr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/evctr_cycles.sv
module evctr_cycles
  import evctr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  output logic [DATA_W-1:0] cyc_o
);
  logic [DATA_W-1:0] cyc_q, cyc_d;

  always_comb begin
    cyc_d = cyc_q + {{(DATA_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cyc_q <= '0;
    else if (active) cyc_q <= cyc_d;
  end

  assign cyc_o = cyc_q;

  assert_cyc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> $stable(cyc_o));
  assert_cyc_moves_R9: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> (cyc_o != $past(cyc_o)));
endmodule

// File: rtl/evctr_slot.sv
module evctr_slot
  import evctr_pkg::*;
#(
  parameter bit               LEGACY     = 1'b0,
  parameter logic [NUM_EVT-1:0] GLOBAL_EVT = 16'hC000
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_THREADS*NUM_EVT-1:0] thr_evt,
  input  logic [NUM_EVT-1:0]             core_evt,
  input  logic                           wr_en,
  input  logic [DATA_W-1:0]              wdata,
  input  logic                           irq_clr,
  output ctr_word_t                      word_o,
  output logic                           irq_o
);
  ctr_word_t              word_q, word_d;
  logic                   irq_q, irq_d;
  logic [NUM_THREADS-1:0] hits;
  logic [INC_W-1:0]       inc;
  logic [CNT_W:0]         sum;
  logic                   wrap;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic [NUM_EVT-1:0] row;
    assign row     = thr_evt[t*NUM_EVT +: NUM_EVT];
    assign hits[t] = word_q.mask[t] & row[word_q.sel];
  end

  always_comb begin
    if (GLOBAL_EVT[word_q.sel]) inc = {{(INC_W-1){1'b0}}, core_evt[word_q.sel]};
    else                        inc = INC_W'($countones(hits));
    sum  = {1'b0, word_q.cnt} + {{(CNT_W+1-INC_W){1'b0}}, inc};
    wrap = sum[CNT_W];
  end

  always_comb begin
    word_d = word_q;
    if (wr_en) begin
      word_d = ctr_word_t'(wdata);
      if (LEGACY) word_d.cnt = '0;
    end else begin
      word_d.cnt = sum[CNT_W-1:0];
    end
  end

  always_comb begin
    if (LEGACY) irq_d = 1'b0;
    else        irq_d = (irq_q & ~irq_clr) | (~wr_en & wrap);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      irq_q  <= irq_d;
    end
  end

  assign word_o = word_q;
  assign irq_o  = irq_q;

  assert_wrap_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!LEGACY && !wr_en && (word_q.cnt == {CNT_W{1'b1}}) && (inc != '0)) |=> irq_o);
  assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_clr) |=> irq_o);
  assert_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && (word_q.sel == '0) && (word_q.mask == '0)) |=> $stable(word_o.cnt));
  assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ({word_o.sel, word_o.mask} == $past(wdata[DATA_W-1:CNT_W])));
  assert_legacy_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    LEGACY |-> !irq_o);
endmodule

// File: rtl/evctr_unit.sv
module evctr_unit
  import evctr_pkg::*;
#(
  parameter bit                 LEGACY     = 1'b0,
  parameter logic [NUM_EVT-1:0] GLOBAL_EVT = 16'hC000,
  parameter int                 ADDR_W     = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_THREADS*NUM_EVT-1:0] thr_evt,
  input  logic [NUM_EVT-1:0]             core_evt,
  input  logic                           thr_active,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic                           bus_we,
  input  logic [DATA_W-1:0]              bus_wdata,
  output logic [DATA_W-1:0]              bus_rdata,
  output logic [NUM_CTR-1:0]             irq_ovf
);
  localparam int IDX_W = ADDR_W - REG_SH;
  localparam logic [IDX_W-1:0] IDX_CYC  = IDX_W'(NUM_CTR);
  localparam logic [IDX_W-1:0] IDX_STAT = IDX_W'(NUM_CTR + 1);

  logic              rst_q_n;
  logic [IDX_W-1:0]  reg_idx;
  logic              stat_we;
  logic [DATA_W-1:0] cyc;
  ctr_word_t         words [NUM_CTR];

  assign reg_idx = bus_addr[ADDR_W-1:REG_SH];
  assign stat_we = bus_we && (reg_idx == IDX_STAT);

  evctr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n));

  for (genvar c = 0; c < NUM_CTR; c++) begin : g_ctr
    logic wr_c;
    assign wr_c = bus_we && (reg_idx == IDX_W'(c));
    evctr_slot #(.LEGACY(LEGACY), .GLOBAL_EVT(GLOBAL_EVT)) u_slot (
      .clk     (clk),
      .rst_n   (rst_q_n),
      .thr_evt (thr_evt),
      .core_evt(core_evt),
      .wr_en   (wr_c),
      .wdata   (bus_wdata),
      .irq_clr (stat_we && bus_wdata[c]),
      .word_o  (words[c]),
      .irq_o   (irq_ovf[c])
    );
  end

  evctr_cycles u_cyc (.clk(clk), .rst_n(rst_q_n), .active(thr_active), .cyc_o(cyc));

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NUM_CTR; c++)
      if (reg_idx == IDX_W'(c)) bus_rdata = words[c];
    if (reg_idx == IDX_CYC)  bus_rdata = cyc;
    if (reg_idx == IDX_STAT) bus_rdata = {{(DATA_W-NUM_CTR){1'b0}}, irq_ovf};
  end

  assert_reset_clear_R11: assert property (@(posedge clk)
    !rst_q_n |=> (irq_ovf == '0) || !rst_q_n);
endmodule

// File: tb/test_evctr_unit.sv
module test_evctr_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] thr_evt;
  logic [15:0] core_evt;
  logic        thr_active;
  logic [4:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] rdata [2];
  logic [1:0]  irq   [2];

  always #2 clk = ~clk;   // 250 MHz

  evctr_unit #(.LEGACY(1'b0)) i_evctr_unit (
    .clk(clk), .rst_n(rst_n), .thr_evt(thr_evt), .core_evt(core_evt),
    .thr_active(thr_active), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(rdata[0]), .irq_ovf(irq[0]));

  evctr_unit #(.LEGACY(1'b1)) i_evctr_unit_legacy (
    .clk(clk), .rst_n(rst_n), .thr_evt(thr_evt), .core_evt(core_evt),
    .thr_active(thr_active), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(rdata[1]), .irq_ovf(irq[1]));

  // Reference model, unit 0 normal, unit 1 legacy
  int unsigned m_ctl [2][2];
  int unsigned m_cnt [2][2];
  bit          m_irq [2][2];
  int unsigned m_cyc [2];
  bit          run = 0;
  bit          done = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  int          wd = 0;

  always @(posedge clk) begin
    if (run) begin
      for (int u = 0; u < 2; u++) begin
        for (int c = 0; c < 2; c++) begin
          int unsigned sel, msk, inc, s;
          bit hit, clr;
          sel = m_ctl[u][c] >> 4;
          msk = m_ctl[u][c] & 15;
          inc = 0;
          if (sel >= 14) inc = core_evt[sel];
          else for (int t = 0; t < 4; t++)
            if (msk[t] && thr_evt[t*16 + sel]) inc++;
          hit = bus_we && ((bus_addr >> 3) == c);
          clr = bus_we && ((bus_addr >> 3) == 3) && bus_wdata[c];
          if (clr) m_irq[u][c] = 0;
          if (hit) begin
            m_ctl[u][c] = bus_wdata >> 24;
            m_cnt[u][c] = (u == 1) ? 0 : (bus_wdata & 32'hFFFFFF);
          end else begin
            s = m_cnt[u][c] + inc;
            if (s > 32'hFFFFFF && u == 0) m_irq[u][c] = 1;
            m_cnt[u][c] = s & 32'hFFFFFF;
          end
        end
        if (thr_active) m_cyc[u] = m_cyc[u] + 1;
      end
    end
  end

  function automatic logic [31:0] exp_read(int u, logic [4:0] a);
    case (a >> 3)
      0: return {m_ctl[u][0][7:0], m_cnt[u][0][23:0]};
      1: return {m_ctl[u][1][7:0], m_cnt[u][1][23:0]};
      2: return m_cyc[u];
      default: return {30'd0, m_irq[u][1], m_irq[u][0]};
    endcase
  endfunction

  // irq lines compared on every falling edge (R5, R6, R10)
  always @(negedge clk) begin
    if (run && !done) begin
      for (int u = 0; u < 2; u++) begin
        n_chk++;
        if (irq[u] !== {m_irq[u][1], m_irq[u][0]}) begin
          n_fail++;
          $display("FAIL R5/R6/R10 irq unit %0d: got %b exp %b", u, irq[u],
                   {m_irq[u][1], m_irq[u][0]});
        end
      end
    end
  end

  task automatic finish_tb();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 20000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      finish_tb();
    end
  end

  task automatic idle_inputs();
    thr_evt = '0; core_evt = '0; thr_active = 0; bus_we = 0; bus_wdata = '0;
  endtask

  task automatic step(input bit we, input logic [4:0] a, input logic [31:0] d,
                      input logic [63:0] te, input logic [15:0] ce, input bit act);
    bus_we = we; bus_addr = a; bus_wdata = d;
    thr_evt = te; core_evt = ce; thr_active = act;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic chk_read(input logic [4:0] a, input string tag);
    bus_addr = a;
    #1;
    for (int u = 0; u < 2; u++) begin
      n_chk++;
      if (rdata[u] !== exp_read(u, a)) begin
        n_fail++;
        $display("FAIL %s unit %0d addr %h: got %h exp %h", tag, u, a, rdata[u],
                 exp_read(u, a));
      end
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    step(1, a, d, '0, '0, 0);
  endtask

  initial begin
    for (int u = 0; u < 2; u++) begin
      m_cyc[u] = 0;
      for (int c = 0; c < 2; c++) begin
        m_ctl[u][c] = 0; m_cnt[u][c] = 0; m_irq[u][c] = 0;
      end
    end
    idle_inputs();
    bus_addr = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    run = 1;

    // R11 reset state, R1 map
    chk_read(5'h00, "R11"); chk_read(5'h08, "R11");
    chk_read(5'h10, "R11"); chk_read(5'h18, "R11");

    // R7/R10 write: event 2, threads 0 and 1, count 5
    wr(5'h00, 32'h2300_0005);
    chk_read(5'h00, "R7"); chk_read(5'h04, "R1");

    // R2 two threads strobe event 2 in one cycle
    step(0, 5'h00, '0, 64'h0000_0000_0004_0004, '0, 0);
    chk_read(5'h00, "R2");
    step(0, 5'h00, '0, 64'h0000_0000_0000_0004, '0, 0);
    chk_read(5'h00, "R2");

    // R3 unmasked thread and wrong event
    step(0, 5'h00, '0, 64'h0004_0004_0008_0008, '0, 0);
    chk_read(5'h00, "R3");

    // R9 active cycles, write ignored
    step(0, 5'h10, '0, '0, '0, 1);
    step(0, 5'h10, '0, '0, '0, 1);
    step(0, 5'h10, '0, '0, '0, 1);
    chk_read(5'h10, "R9");
    wr(5'h10, 32'h0000_FFFF);
    chk_read(5'h10, "R9");

    // R8 core-wide event 15 with all threads strobing it
    wr(5'h08, 32'hFF00_0000);
    step(0, 5'h08, '0, 64'h8000_8000_8000_8000, 16'h8000, 0);
    chk_read(5'h08, "R8");
    step(0, 5'h08, '0, 64'h8000_8000_8000_8000, 16'h0000, 0);
    chk_read(5'h08, "R8");

    // R4 stopped counter holds count
    wr(5'h00, 32'h0000_0ABC);
    step(0, 5'h00, '0, '1, '1, 0);
    chk_read(5'h00, "R4");

    // R7 write wins over same-cycle increment
    step(1, 5'h00, 32'h2100_0010, 64'h0000_0000_0000_0004, '0, 0);
    chk_read(5'h00, "R7");

    // R5 wrap on counter 0
    wr(5'h00, 32'h23FF_FFFE);
    step(0, 5'h00, '0, 64'h0000_0000_0004_0004, '0, 0);
    chk_read(5'h00, "R5"); chk_read(5'h18, "R5");
    chk_read(5'h18, "R10");
    repeat (3) step(0, 5'h18, '0, '0, '0, 0);
    chk_read(5'h18, "R6");
    wr(5'h18, 32'h0000_0002);
    chk_read(5'h18, "R6");
    wr(5'h18, 32'h0000_0001);
    chk_read(5'h18, "R6");

    // R5 separate line for counter 1
    wr(5'h08, 32'hF0FF_FFFF);
    step(0, 5'h08, '0, '0, 16'h8000, 0);
    chk_read(5'h18, "R5"); chk_read(5'h08, "R5");

    // R6 wrap and clear in the same cycle: set wins
    wr(5'h08, 32'hF0FF_FFFF);
    step(1, 5'h18, 32'h0000_0002, '0, 16'h8000, 0);
    chk_read(5'h18, "R6");
    wr(5'h18, 32'h0000_0003);
    chk_read(5'h18, "R6");

    repeat (2) @(negedge clk);
    finish_tb();
  end
endmodule